// File: doc/BRIEF.md
# Serial CRC-3 Framer and Checker

This unit protects short serial messages with a three-bit cyclic check. The generator is x^3 + x^2 + 1. In send mode it passes each message bit straight through and then adds the three-bit remainder after the last message bit. The remainder is that of the message multiplied by x^3, which is the message with three zero bits appended. The finished frame is an exact multiple of the generator. In check mode the whole incoming frame goes through the same divider. One cycle after the last bit the unit reports whether the remainder was zero. Only the message part is forwarded: a three-stage holding line keeps the trailing check bits from ever reaching the output.

Bits move one per handshake on a valid/ready serial stream. Start and end markers travel with the bits. The `rx_mode` input is sampled with the start bit of each frame. The controller has five states. ST_IDLE waits for a start bit. ST_TX_MSG forwards message bits. ST_TX_CHK shifts out the three check bits. ST_RX_FILL loads the first three frame bits into the holding line. ST_RX_PASS forwards the oldest held bit each time a new bit arrives.

The transitions are as follows:
- start in send mode: ST_IDLE to ST_TX_MSG, or to ST_TX_CHK for a one-bit message.
- message end: ST_TX_MSG to ST_TX_CHK.
- third check bit emitted: ST_TX_CHK to ST_IDLE.
- start in check mode: ST_IDLE to ST_RX_FILL.
- line full: ST_RX_FILL to ST_RX_PASS.
- frame end: ST_RX_FILL or ST_RX_PASS to ST_IDLE.

Top module: `crc_serial_unit`

## Requirements
- R1: The divider uses the generator 1101 (x^3+x^2+1). It takes bits most significant first, one per accepted input bit, and its remainder starts from zero with every accepted start bit.
- R2: In send mode the output frame is every message bit unchanged, in order, followed by the three-bit remainder of (message times x^3) mod 1101, highest remainder bit first. out_sof marks only the first output bit and out_eof marks only the last check bit. Check mode pulses never fire for a sent frame.
- R3: After reset, out_valid, crc_ok and crc_err are low and in_ready is high. In send mode, an accepted message bit is on out_bit in the next cycle. in_ready stays low for exactly the three cycles in which the check bits leave when out_ready is held high.
- R4: The 16-bit message 0xD6B5 produces check bits 101, and the 19-bit frame 0x6B5AD.
- R5: In check mode a frame of four or more bits that is an exact multiple of 1101 gives a one-cycle crc_ok pulse in the cycle after its end bit is accepted. Any other remainder gives a crc_err pulse in the same cycle. The two never fire together.
- R6: In check mode the output is the frame without its last three bits, in order. out_sof marks the first forwarded bit and out_eof the last one. Check bits never appear on the output.
- R7: A check mode frame of three bits or fewer, including 000, gives crc_err and no output bits.
- R8: Flipping any single one of the 19 bits of frame 0x6B5AD makes check mode report crc_err.
- R9: While out_valid is high and out_ready is low, out_valid, out_bit, out_sof and out_eof hold. No bit is lost or repeated under backpressure.
- R10: Bits accepted in ST_IDLE without the start marker are discarded: they produce no output and no pulse.
- R11: rx_mode is only sampled with the start bit. Toggling it inside a frame does not change how that frame is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_mode | input | 1 | 1 = check frames, 0 = add check bits; sampled with the start bit |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Unit accepts the input bit this cycle |
| in_bit | input | 1 | Serial input bit |
| in_sof | input | 1 | Input bit is the first of a frame |
| in_eof | input | 1 | Input bit is the last of a frame |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Sink accepts the output bit |
| out_bit | output | 1 | Serial output bit |
| out_sof | output | 1 | Output bit is the first of a frame |
| out_eof | output | 1 | Output bit is the last of a frame |
| crc_ok | output | 1 | One-cycle pulse: checked frame divides evenly |
| crc_err | output | 1 | One-cycle pulse: checked frame is corrupt or too short |

## Verification
The fixed 0xD6B5 message and its 19-bit frame pin down the polynomial, the bit order and the placement of the check bits. All 19 single-bit flips of that frame show that no position escapes detection. Seeded random messages of 1 to 40 bits, sent with random input gaps and random output stalls, are compared against a long-division model. In check mode, valid frames are mixed with raw random ones so that both verdicts occur. Frames of one to three bits, stray bits without a start marker, and a mode flip inside a frame cover the paths where the unit must produce nothing, or must ignore an input.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_MSG,
        ST_TX_CHK,
        ST_RX_FILL,
        ST_RX_PASS
    } crc_state_e;

endpackage

// File: rtl/crc_divider.sv
// Bit-serial modulo-2 divider. Each step folds one data bit into the
// remainder; the feedback taps follow the generator coefficients.
module crc_divider #(
    parameter int              DEG  = 3,
    parameter logic [DEG:0]    POLY = 4'b1101
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    input  logic           din,
    output logic [DEG-1:0] rem_q,
    output logic [DEG-1:0] rem_nxt
);

    logic [DEG-1:0] base;
    logic           fb;

    assign base = clear ? '0 : rem_q;
    assign fb   = base[DEG-1] ^ din;

    for (genvar i = 0; i < DEG; i++) begin : g_tap
        if (i == 0) begin : g_lsb
            assign rem_nxt[i] = fb & POLY[0];
        end else begin : g_mid
            assign rem_nxt[i] = base[i-1] ^ (fb & POLY[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (step) begin
            rem_q <= rem_nxt;
        end
    end

    // R1: remainder only moves on an accepted step
    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(rem_q));

endmodule

// File: rtl/crc_holdback.sv
// Short delay line that keeps the newest DEPTH frame bits back from the
// output, so trailing check bits are never forwarded.
module crc_holdback #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift,
    input  logic din,
    output logic oldest
);

    logic [DEPTH-1:0] dly;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly <= '0;
        end else if (shift) begin
            dly <= clear ? {{(DEPTH-1){1'b0}}, din} : {dly[DEPTH-2:0], din};
        end
    end

    assign oldest = dly[DEPTH-1];

    // R6: every shifted bit enters the line
    p_line_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (dly[0] == $past(din)));

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
    import crc_serial_pkg::*;
#(
    parameter int           DEG  = 3,
    parameter logic [DEG:0] POLY = 4'b1101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_mode,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    input  logic in_sof,
    input  logic in_eof,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit,
    output logic out_sof,
    output logic out_eof,
    output logic crc_ok,
    output logic crc_err
);

    localparam int             CW   = $clog2(DEG + 1);
    localparam logic [CW-1:0]  LAST = CW'(DEG - 1);

    crc_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           first_q, first_d;

    logic           adv, acc;
    logic           div_clr, div_step, div_din;
    logic [DEG-1:0] rem_q, rem_nxt;
    logic           hb_clr, hb_shift, hb_oldest;
    logic           ld, ld_bit, ld_sof, ld_eof;
    logic           ok_d, err_d;

    crc_divider #(.DEG(DEG), .POLY(POLY)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (div_clr),
        .step    (div_step),
        .din     (div_din),
        .rem_q   (rem_q),
        .rem_nxt (rem_nxt)
    );

    crc_holdback #(.DEPTH(DEG)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (hb_clr),
        .shift  (hb_shift),
        .din    (in_bit),
        .oldest (hb_oldest)
    );

    // output slot may take a new bit
    assign adv = !out_valid || out_ready;
    assign acc = in_valid && in_ready;

    always_comb begin
        unique case (state_q)
            ST_TX_CHK: in_ready = 1'b0;
            default:   in_ready = adv;
        endcase
    end

    // next state and datapath control
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        first_d  = first_q;
        div_clr  = 1'b0;
        div_step = 1'b0;
        div_din  = in_bit;
        hb_clr   = 1'b0;
        hb_shift = 1'b0;
        ld       = 1'b0;
        ld_bit   = in_bit;
        ld_sof   = 1'b0;
        ld_eof   = 1'b0;
        ok_d     = 1'b0;
        err_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (acc && in_sof) begin
                    div_clr  = 1'b1;
                    div_step = 1'b1;
                    if (rx_mode) begin
                        hb_clr   = 1'b1;
                        hb_shift = 1'b1;
                        cnt_d    = CW'(1);
                        first_d  = 1'b1;
                        if (in_eof) err_d   = 1'b1;
                        else        state_d = ST_RX_FILL;
                    end else begin
                        ld     = 1'b1;
                        ld_sof = 1'b1;
                        if (in_eof) begin
                            state_d = ST_TX_CHK;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_TX_MSG;
                        end
                    end
                end
            end
            ST_TX_MSG: begin
                if (acc) begin
                    div_step = 1'b1;
                    ld       = 1'b1;
                    if (in_eof) begin
                        state_d = ST_TX_CHK;
                        cnt_d   = '0;
                    end
                end
            end
            ST_TX_CHK: begin
                if (adv) begin
                    div_step = 1'b1;
                    div_din  = rem_q[DEG-1];
                    ld       = 1'b1;
                    ld_bit   = rem_q[DEG-1];
                    cnt_d    = cnt_q + CW'(1);
                    if (cnt_q == LAST) begin
                        ld_eof  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_RX_FILL: begin
                if (acc) begin
                    div_step = 1'b1;
                    hb_shift = 1'b1;
                    cnt_d    = cnt_q + CW'(1);
                    if (in_eof) begin
                        err_d   = 1'b1;
                        state_d = ST_IDLE;
                    end else if (cnt_q == LAST) begin
                        state_d = ST_RX_PASS;
                    end
                end
            end
            ST_RX_PASS: begin
                if (acc) begin
                    div_step = 1'b1;
                    hb_shift = 1'b1;
                    ld       = 1'b1;
                    ld_bit   = hb_oldest;
                    ld_sof   = first_q;
                    first_d  = 1'b0;
                    if (in_eof) begin
                        ld_eof  = 1'b1;
                        ok_d    = (rem_nxt == '0);
                        err_d   = (rem_nxt != '0);
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            first_q <= first_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            crc_ok    <= 1'b0;
            crc_err   <= 1'b0;
        end else begin
            if (adv) begin
                out_valid <= ld;
                out_bit   <= ld_bit;
                out_sof   <= ld_sof;
                out_eof   <= ld_eof;
            end
            crc_ok  <= ok_d;
            crc_err <= err_d;
        end
    end

    // R9: a stalled output bit holds until taken
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)
                                       && $stable(out_sof) && $stable(out_eof)));

    // R5: verdicts are exclusive
    p_verdict_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok && crc_err));

    // R5: a verdict only follows an accepted end bit
    p_verdict_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok || crc_err) |-> $past(in_valid && in_ready && in_eof));

    // R5: the good-frame pulse lasts one cycle
    p_ok_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |=> !crc_ok);

    // R2: once the check bits are out, the sent frame divides evenly
    p_frame_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX_CHK && adv && cnt_q == LAST) |=> (rem_q == '0));

endmodule

// File: tb/tb_crc_serial_unit.sv
`timescale 1ns/1ps
module tb_crc_serial_unit;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, rx_mode, in_valid, in_ready, in_bit, in_sof, in_eof;
    logic out_valid, out_ready, out_bit, out_sof, out_eof, crc_ok, crc_err;

    crc_serial_unit #(.DEG(3), .POLY(4'b1101)) dut (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
        .out_sof(out_sof), .out_eof(out_eof),
        .crc_ok(crc_ok), .crc_err(crc_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit bp_en = 1'b0;

    logic fb [0:255];
    logic gb [0:255];
    logic gs [0:255];
    logic ge [0:255];
    int   gn, okc, errc;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && gn < 256) begin
                gb[gn] = out_bit;
                gs[gn] = out_sof;
                ge[gn] = out_eof;
                gn++;
            end
            if (crc_ok)  okc++;
            if (crc_err) errc++;
        end
    end

    always @(posedge clk) begin
        #1;
        out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
    end

    // remainder of the polynomial in fb[0..n-1] (plus 3 zeros if aug) mod 1101
    function automatic logic [2:0] rem_of(input int n, input bit aug);
        logic w [0:259];
        int   len;
        len = aug ? n + 3 : n;
        for (int i = 0; i < 260; i++) w[i] = (i < n) ? fb[i] : 1'b0;
        for (int i = 0; i + 3 < len; i++) begin
            if (w[i]) begin
                w[i]   = ~w[i];
                w[i+1] = ~w[i+1];
                w[i+3] = ~w[i+3];
            end
        end
        return {w[len-3], w[len-2], w[len-1]};
    endfunction

    task automatic clear_mon();
        gn = 0; okc = 0; errc = 0;
    endtask

    // caller is at posedge+1
    task automatic send_frame(input int n, input bit mode, input bit gaps,
                              input int flip_at, input bit with_sof);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 3) == 0) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_bit   = fb[i];
            in_sof   = with_sof && (i == 0);
            in_eof   = (i == n - 1);
            rx_mode  = (i >= flip_at) ? ~mode : mode;
            forever begin
                @(negedge clk);
                if (in_ready) break;
                @(posedge clk); #1;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic drain();
        bp_en = 1'b0;
        repeat (10) @(posedge clk);
        #1;
    endtask

    task automatic do_tx(input int n, input bit gaps, input bit probe, input int flip_at);
        logic [2:0] r;
        int errs, sof_bad, eof_bad;
        clear_mon();
        r = rem_of(n, 1'b1);
        bp_en = !probe;
        send_frame(n, 1'b0, gaps, flip_at, 1'b1);
        if (probe) begin
            @(negedge clk);
            check("R3 latency out_valid", out_valid, 1);
            check("R3 latency out_bit", out_bit, fb[n-1]);
            check("R3 ready low chk0", in_ready, 0);
            for (int k = 1; k < 3; k++) begin
                @(posedge clk); #1;
                @(negedge clk);
                check("R3 ready low during check bits", in_ready, 0);
            end
            @(posedge clk); #1;
            @(negedge clk);
            check("R3 ready back high", in_ready, 1);
            @(posedge clk); #1;
        end
        drain();
        check("R2 tx bit count", gn, n + 3);
        errs = 0; sof_bad = 0; eof_bad = 0;
        for (int i = 0; i < n + 3 && i < gn; i++) begin
            if (gb[i] !== ((i < n) ? fb[i] : r[2-(i-n)])) errs++;
            if (gs[i] !== (i == 0)) sof_bad++;
            if (ge[i] !== (i == n + 2)) eof_bad++;
        end
        check("R2 tx bit mismatches", errs, 0);
        check("R2 tx sof marks", sof_bad, 0);
        check("R2 tx eof marks", eof_bad, 0);
        check("R2 tx no pulses", okc + errc, 0);
    endtask

    task automatic do_rx(input int n, input bit gaps, input int flip_at);
        bit good;
        int errs, sof_bad, eof_bad;
        clear_mon();
        good = (n > 3) && (rem_of(n, 1'b0) == 3'b000);
        bp_en = 1'b1;
        send_frame(n, 1'b1, gaps, flip_at, 1'b1);
        drain();
        if (n <= 3) begin
            check("R7 short frame output", gn, 0);
            check("R7 short frame err", errc, 1);
            check("R7 short frame ok", okc, 0);
        end else begin
            check("R6 rx bit count", gn, n - 3);
            errs = 0; sof_bad = 0; eof_bad = 0;
            for (int i = 0; i < n - 3 && i < gn; i++) begin
                if (gb[i] !== fb[i]) errs++;
                if (gs[i] !== (i == 0)) sof_bad++;
                if (ge[i] !== (i == n - 4)) eof_bad++;
            end
            check("R6 rx bit mismatches", errs, 0);
            check("R6 rx sof/eof marks", sof_bad + eof_bad, 0);
            check("R5 rx ok count", okc, good ? 1 : 0);
            check("R5 rx err count", errc, good ? 0 : 1);
        end
    endtask

    task automatic load_word(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) fb[i] = v[n-1-i];
    endtask

    initial begin
        int n;
        logic [2:0] r;
        logic [18:0] word;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; rx_mode = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
        in_sof = 1'b0; in_eof = 1'b0; out_ready = 1'b1;
        clear_mon();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 reset out_valid", out_valid, 0);
        check("R3 reset pulses", crc_ok + crc_err, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        check("R3 idle in_ready", in_ready, 1);
        @(posedge clk); #1;

        // R4 / R1: directed vector, unstalled, with timing probe
        load_word(32'hD6B5, 16);
        do_tx(16, 1'b0, 1'b1, 256);
        check("R4 check bits", {gb[16], gb[17], gb[18]}, 3'b101);
        word = '0;
        for (int i = 0; i < 19; i++) word = {word[17:0], gb[i]};
        check("R4 frame word", int'(word), 32'h6B5AD);

        load_word(32'h6B5AD, 19);
        do_rx(19, 1'b0, 256);
        check("R5 good vector ok", okc, 1);

        // R8: every single-bit flip is caught
        for (int p = 0; p < 19; p++) begin
            load_word(32'h6B5AD, 19);
            fb[p] = ~fb[p];
            do_rx(19, 1'b0, 256);
            check($sformatf("R8 flip bit %0d err", p), errc, 1);
        end

        // R7: short frames, including all-zero
        for (int k = 1; k <= 3; k++) begin
            for (int i = 0; i < k; i++) fb[i] = 1'b0;
            do_rx(k, 1'b0, 256);
        end

        // R10: stray bits without start marker
        clear_mon();
        for (int i = 0; i < 5; i++) fb[i] = 1'($urandom);
        send_frame(5, 1'b0, 1'b0, 256, 1'b0);
        send_frame(5, 1'b1, 1'b0, 256, 1'b0);
        drain();
        check("R10 stray output", gn, 0);
        check("R10 stray pulses", okc + errc, 0);

        // R11: mode flips inside frames
        for (int i = 0; i < 8; i++) fb[i] = 1'($urandom);
        do_tx(8, 1'b1, 1'b0, 3);
        load_word(32'h6B5AD, 19);
        do_rx(19, 1'b1, 5);

        // R2 / R9: random send frames with gaps and stalls
        for (int t = 0; t < 30; t++) begin
            n = 1 + int'($urandom % 40);
            for (int i = 0; i < n; i++) fb[i] = 1'($urandom);
            do_tx(n, 1'b1, 1'b0, 256);
        end

        // R5 / R6 / R9: random check frames, valid and raw
        for (int t = 0; t < 30; t++) begin
            if (t % 2 == 0) begin
                n = 1 + int'($urandom % 36);
                for (int i = 0; i < n; i++) fb[i] = 1'($urandom);
                r = rem_of(n, 1'b1);
                fb[n] = r[2]; fb[n+1] = r[1]; fb[n+2] = r[0];
                n = n + 3;
            end else begin
                n = 4 + int'($urandom % 37);
                for (int i = 0; i < n; i++) fb[i] = 1'($urandom);
            end
            do_rx(n, 1'b1, 256);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule